// File: doc/BRIEF.md
# Mode-Selected Arithmetic Logic Unit

This block is a purely combinational ALU with a parameterised operand width (8 bits by default). One parallel adder produces eight arithmetic operations. Per-bit steering logic turns the second operand into zero, B, the complement of B or all ones, and the carry-in is then added in. A separate bitwise section gives four logic operations. A mode bit picks which of the two results reaches the output, for twelve operations in total.

Four status flags come with every result: carry, overflow, sign and zero. A control unit can use them to make decisions. The block holds no state. A datapath uses it between its operand buses and its result bus.

Top module: `alu_core`

## Requirements
- R1: `sel_mode` = 0 selects the arithmetic result and `sel_mode` = 1 selects the logic result on `result`.
- R2: In arithmetic mode the adder's second operand Y is formed per bit from `sel_op` and B: 00 gives 0, 01 gives B, 10 gives ~B, 11 gives all ones. `result` = (A + Y + `cin`) mod 2^W.
- R3: With `sel_op`/`cin`, the arithmetic operations are:
  - 00/0 passes A.
  - 00/1 increments A.
  - 01/0 gives A+B.
  - 01/1 gives A+B+1.
  - 10/0 gives A+~B.
  - 10/1 gives A−B.
  - 11/0 decrements A.
  - 11/1 passes A.
- R4: In logic mode `sel_op` 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B and 11 gives NOT A.
- R5: In logic mode `cin` has no effect on `result` or on any flag.
- R6: In arithmetic mode `flag_c` is the carry out of the adder's top bit.
- R7: In arithmetic mode `flag_v` is the XOR of the carries into and out of the top bit. This is equivalent to two's complement overflow of A + Y.
- R8: `flag_n` equals the top bit of `result` in both modes.
- R9: `flag_z` is 1 exactly when `result` is all zeros, in both modes.
- R10: In logic mode `flag_c` and `flag_v` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_a | input | W | First operand A |
| opd_b | input | W | Second operand B |
| sel_mode | input | 1 | 0 arithmetic, 1 logic |
| sel_op | input | 2 | Operation select within the mode |
| cin | input | 1 | Carry-in (arithmetic mode only) |
| result | output | W | Selected result G |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_n | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |

## Verification
All sixteen settings of mode, `sel_op` and `cin` are applied to every pair drawn from the operands 0, 1, 0x7F, 0x80 and 0xFF. These pairs tell carry apart from overflow at the sign boundary. They also produce zero results from increment of all ones and from subtraction of equals. Random operand pairs then cover all sixteen settings in bulk. The logic-mode settings with `cin` high show that the carry-in leaves the result and every flag unchanged.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic {
        MODE_ARITH = 1'b0,
        MODE_LOGIC = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        YSEL_ZERO = 2'b00,
        YSEL_PASS = 2'b01,
        YSEL_INV  = 2'b10,
        YSEL_ONES = 2'b11
    } ysel_e;

    typedef enum logic [1:0] {
        LOP_AND  = 2'b00,
        LOP_OR   = 2'b01,
        LOP_XOR  = 2'b10,
        LOP_NOTA = 2'b11
    } lop_e;

    typedef struct packed {
        logic c;
        logic v;
        logic n;
        logic z;
    } flags_t;

    // One bit of the adder's second operand.
    function automatic logic y_bit(input ysel_e sel, input logic b);
        case (sel)
            YSEL_ZERO: y_bit = 1'b0;
            YSEL_PASS: y_bit = b;
            YSEL_INV:  y_bit = ~b;
            default:   y_bit = 1'b1;
        endcase
    endfunction

    // One bit of the bitwise section.
    function automatic logic lop_bit(input lop_e op, input logic a, input logic b);
        case (op)
            LOP_AND: lop_bit = a & b;
            LOP_OR:  lop_bit = a | b;
            LOP_XOR: lop_bit = a ^ b;
            default: lop_bit = ~a;
        endcase
    endfunction

endpackage

// File: rtl/alu_y_gen.sv
module alu_y_gen
    import alu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  ysel_e          sel,
    input  logic [W-1:0]   b_in,
    output logic [W-1:0]   y_out
);
    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        assign y_out[gi] = y_bit(sel, b_in[gi]);
    end
endmodule

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] y_in,
    input  logic         c_in,
    output logic [W-1:0] sum,
    output logic         c_msb,
    output logic         c_out
);
    logic [W:0] cy;
    assign cy[0] = c_in;

    for (genvar gi = 0; gi < W; gi++) begin : g_fa
        logic p;
        assign p          = a_in[gi] ^ y_in[gi];
        assign sum[gi]    = p ^ cy[gi];
        assign cy[gi+1]   = (a_in[gi] & y_in[gi]) | (p & cy[gi]);
    end

    assign c_msb = cy[W-1];
    assign c_out = cy[W];
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  lop_e         op,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] res
);
    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        assign res[gi] = lop_bit(op, a_in[gi], b_in[gi]);
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] opd_a,
    input  logic [W-1:0] opd_b,
    input  logic         sel_mode,
    input  logic [1:0]   sel_op,
    input  logic         cin,
    output logic [W-1:0] result,
    output logic         flag_c,
    output logic         flag_v,
    output logic         flag_n,
    output logic         flag_z
);
    localparam int unsigned MSB = W - 1;

    mode_e        mode;
    logic [W-1:0] y_opnd;
    logic [W-1:0] arith_res;
    logic [W-1:0] logic_res;
    logic         c_msb;
    logic         c_out;
    flags_t       flg;

    assign mode = mode_e'(sel_mode);

    alu_y_gen #(.W(W)) u_ygen (
        .sel   (ysel_e'(sel_op)),
        .b_in  (opd_b),
        .y_out (y_opnd)
    );

    alu_ripple_add #(.W(W)) u_add (
        .a_in  (opd_a),
        .y_in  (y_opnd),
        .c_in  (cin),
        .sum   (arith_res),
        .c_msb (c_msb),
        .c_out (c_out)
    );

    alu_bitwise #(.W(W)) u_lop (
        .op   (lop_e'(sel_op)),
        .a_in (opd_a),
        .b_in (opd_b),
        .res  (logic_res)
    );

    always_comb begin
        if (mode == MODE_ARITH) begin
            result = arith_res;
            flg.c  = c_out;
            flg.v  = c_msb ^ c_out;
        end else begin
            result = logic_res;
            flg.c  = 1'b0;
            flg.v  = 1'b0;
        end
        flg.n = result[MSB];
        flg.z = ~|result;
    end

    assign flag_c = flg.c;
    assign flag_v = flg.v;
    assign flag_n = flg.n;
    assign flag_z = flg.z;

    // Checks across the separate pieces of logic
    logic [W:0] ref_sum;
    always_comb begin
        ref_sum = {1'b0, opd_a} + {1'b0, y_opnd} + {{W{1'b0}}, cin};
        if (mode == MODE_ARITH) begin
            // R2
            y_zero_chk: assert (sel_op != 2'b00 || y_opnd == '0)
                else $error("Y not zero for select 00");
            // R2
            y_ones_chk: assert (sel_op != 2'b11 || y_opnd == '1)
                else $error("Y not all ones for select 11");
            // R6
            carry_sum_chk: assert ({flag_c, result} == ref_sum)
                else $error("carry/sum mismatch");
            // R7
            signed_ovf_chk: assert (flag_v == ((opd_a[MSB] == y_opnd[MSB]) &&
                                               (result[MSB] != opd_a[MSB])))
                else $error("overflow flag mismatch");
        end else begin
            // R10
            logic_cv_chk: assert (!flag_c && !flag_v)
                else $error("C or V set in logic mode");
            // R4
            not_a_chk: assert (sel_op != 2'b11 || result == ~opd_a)
                else $error("NOT A wrong");
        end
    end
endmodule

// File: tb/sim_alu_core.sv
module sim_alu_core;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic [W-1:0] opd_a, opd_b, result;
    logic         sel_mode, cin;
    logic [1:0]   sel_op;
    logic         flag_c, flag_v, flag_n, flag_z;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    alu_core #(.W(W)) u0 (
        .opd_a(opd_a), .opd_b(opd_b), .sel_mode(sel_mode), .sel_op(sel_op),
        .cin(cin), .result(result), .flag_c(flag_c), .flag_v(flag_v),
        .flag_n(flag_n), .flag_z(flag_z)
    );

    // Reference model: returns {c, v, n, z, result}
    function automatic logic [W+3:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic m, input logic [1:0] op, input logic ci);
        logic [W-1:0] y, r;
        logic [W:0]   s;
        logic         c, v;
        if (!m) begin
            case (op)
                2'b00: y = '0;
                2'b01: y = b;
                2'b10: y = ~b;
                default: y = '1;
            endcase
            s = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, ci};
            r = s[W-1:0];
            c = s[W];
            v = (a[W-1] == y[W-1]) && (r[W-1] != a[W-1]);
        end else begin
            case (op)
                2'b00: r = a & b;
                2'b01: r = a | b;
                2'b10: r = a ^ b;
                default: r = ~a;
            endcase
            c = 1'b0;
            v = 1'b0;
        end
        return {c, v, r[W-1], (r == '0), r};
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h m=%0d op=%0d cin=%0d actual=%h expected=%h",
                     tag, opd_a, opd_b, sel_mode, sel_op, cin, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic m, input logic [1:0] op, input logic ci);
        logic [W+3:0] e;
        @(posedge clk);
        opd_a = a; opd_b = b; sel_mode = m; sel_op = op; cin = ci;
        @(negedge clk);
        e = model(a, b, m, op, ci);
        if (!m) chk("R1 R2 R3 result", result, e[W-1:0]);
        else    chk(ci ? "R1 R4 R5 result" : "R1 R4 result", result, e[W-1:0]);
        chk(m ? "R10 C" : "R6 C", {{(W-1){1'b0}}, flag_c}, {{(W-1){1'b0}}, e[W+3]});
        chk(m ? "R10 V" : "R7 V", {{(W-1){1'b0}}, flag_v}, {{(W-1){1'b0}}, e[W+2]});
        chk("R8 N", {{(W-1){1'b0}}, flag_n}, {{(W-1){1'b0}}, e[W+1]});
        chk("R9 Z", {{(W-1){1'b0}}, flag_z}, {{(W-1){1'b0}}, e[W]});
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        logic [W-1:0] corners [5];
        void'($urandom(32'd1234));
        corners[0] = 8'h00; corners[1] = 8'h01; corners[2] = 8'h7F;
        corners[3] = 8'h80; corners[4] = 8'hFF;
        opd_a = '0; opd_b = '0; sel_mode = 1'b0; sel_op = 2'b00; cin = 1'b0;
        for (int ia = 0; ia < 5; ia++)
            for (int ib = 0; ib < 5; ib++)
                for (int s = 0; s < 16; s++)
                    apply(corners[ia], corners[ib], s[3], s[2:1], s[0]);
        for (int k = 0; k < 400; k++)
            for (int s = 0; s < 16; s++)
                apply(W'($urandom), W'($urandom), s[3], s[2:1], s[0]);
        done = 1'b1;
        finish_run();
    end

    initial begin
        for (int n = 0; n < 150000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            finish_run();
        end
    end
endmodule